// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block is the host side of an 8-bit asynchronous NAND flash bus. It drives the shared data lines, the command-latch and address-latch enables, chip enable, and the write and read strobes. It also watches the ready/busy line. A user issues one request at a time. The request carries an operation code, a row address, a column address and a byte count. The block then emits the command, address and data bus cycles in the order that operation requires. Where the flash needs time to work, it waits for ready/busy to fall and rise again.

Write data is pulled from the user one byte at a time through a ready/valid handshake. Read data is returned one byte at a time with a one-cycle valid pulse. Every bus cycle has three parts: a setup time before the strobe falls, a strobe-low time and a hold time after the strobe rises. Each part is a count of system clocks set by a parameter. A ready/busy wait that runs longer than a parameterised number of clocks ends the operation with an error pulse.

Top module: `nand_seq_host`

## Requirements
- R1: After reset, and whenever no operation is active, chip enable is high, both strobes are high, the command-latch and address-latch enables are low, the data lines are not driven, and `req_ready` is high.
- R2: A command byte is presented with the command-latch enable high and the address-latch enable low. The byte is held stable on the data lines for the whole time the write strobe is low, and the flash latches it on the strobe's rising edge.
- R3: An address byte is presented with the address-latch enable high and the command-latch enable low. Program and read send column low, column high, row low, row high. Erase sends row low, then row high. Random-column operations send column low, then column high. Read-ID sends a single 0x00.
- R4: The operation codes map to these bus sequences:
  - 0 (reset): 0xFF.
  - 1 (status): 0x70.
  - 2 (ID): 0x90, one address.
  - 3 (erase): 0x60, two addresses, 0xD0.
  - 4 (program): 0x80, four addresses, data, 0x10.
  - 5 (random-column program): 0x85, two addresses, data, 0x10.
  - 6 (read): 0x00, four addresses, 0x30.
  - 7 (random-column read): 0x05, two addresses, 0xE0.
- R5: Write data is taken when `wr_ready` and `wr_valid` are both high at a clock edge. Each byte is sent in one data cycle, in the order it was accepted, with both latch enables low.
- R6: For a read data cycle the block releases the data lines before the read strobe falls. It keeps them released while the strobe is low, and it returns the byte present just before the strobe rises on `rd_data`, with `rd_valid` high for one cycle.
- R7: Operations 0, 3, 4, 5 and 6 wait after their final command until ready/busy has gone low and then high again. No strobe is pulsed during the wait. For operation 6, the data is read only after the wait ends.
- R8: If a ready/busy wait has not ended within `TIMEOUT_CYC` clocks, `err` and `done` pulse together and the block returns to idle.
- R9: The number of data bytes moved is the following:
  - Status always moves one byte.
  - ID always moves four bytes.
  - Reset and erase move none.
  - Every other operation moves `req_len` bytes, capped at `PAGE_BYTES` (2112). A `req_len` of 0 produces no data cycles.
- R10: Every write or read strobe stays low for exactly `T_LOW` clocks.
- R11: Operation 7 and the read-only operations 1 and 2 finish without any ready/busy wait. They complete without error even when ready/busy never moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an operation (taken while req_ready is high) |
| req_op | input | 3 | Operation code, see R4 |
| req_row | input | 16 | Row (page) address |
| req_col | input | 16 | Column (byte) address |
| req_len | input | LEN_W | Data byte count |
| req_ready | output | 1 | Block is idle and accepts a request |
| done | output | 1 | One-cycle pulse when an operation ends |
| err | output | 1 | One-cycle pulse with done on a ready/busy timeout |
| wr_data | input | 8 | Next byte to program |
| wr_valid | input | 1 | wr_data holds a byte |
| wr_ready | output | 1 | Block takes wr_data at this edge if wr_valid is high |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | rd_data is new this cycle |
| nand_io | inout | 8 | Flash data lines |
| nand_cle | output | 1 | Command-latch enable |
| nand_ale | output | 1 | Address-latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
Each bus cycle lasts `T_SETUP + T_LOW + T_HIGH` clocks, followed by one clock to decode the next step. A read byte appears on `rd_data` one clock after the end of its strobe-low phase. The end of a busy wait is seen two synchronizer clocks after ready/busy rises. These latencies depend on the parameters, so the bench does not count cycles to a result. A flash model logs every byte at the rising edge of the write strobe, and the bench compares that log with the expected sequence after `done`. Read bytes are collected on the clock's falling edge while `rd_valid` is high. Strobe widths and any strobe pulsed during busy are monitored on each falling clock edge and compared against R10 and R7.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_STATUS = 3'd1,
    OP_READID = 3'd2,
    OP_ERASE  = 3'd3,
    OP_PROG   = 3'd4,
    OP_RPROG  = 3'd5,
    OP_READ   = 3'd6,
    OP_RREAD  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    K_CMD, K_ADDR, K_WDATA, K_RDATA, K_WAIT, K_END
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] val;
  } step_t;

  function automatic step_t mk(kind_e k, logic [7:0] v);
    step_t s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  // Step idx of an operation: what kind of bus action and which byte
  function automatic step_t step_of(op_e op, logic [3:0] idx,
                                    logic [15:0] row, logic [15:0] col);
    step_t s;
    s = mk(K_END, 8'h00);
    case (op)
      OP_RESET: case (idx)
        4'd0: s = mk(K_CMD, 8'hFF);
        4'd1: s = mk(K_WAIT, 8'h00);
        default: ;
      endcase
      OP_STATUS: case (idx)
        4'd0: s = mk(K_CMD, 8'h70);
        4'd1: s = mk(K_RDATA, 8'h00);
        default: ;
      endcase
      OP_READID: case (idx)
        4'd0: s = mk(K_CMD, 8'h90);
        4'd1: s = mk(K_ADDR, 8'h00);
        4'd2: s = mk(K_RDATA, 8'h00);
        default: ;
      endcase
      OP_ERASE: case (idx)
        4'd0: s = mk(K_CMD, 8'h60);
        4'd1: s = mk(K_ADDR, row[7:0]);
        4'd2: s = mk(K_ADDR, row[15:8]);
        4'd3: s = mk(K_CMD, 8'hD0);
        4'd4: s = mk(K_WAIT, 8'h00);
        default: ;
      endcase
      OP_PROG: case (idx)
        4'd0: s = mk(K_CMD, 8'h80);
        4'd1: s = mk(K_ADDR, col[7:0]);
        4'd2: s = mk(K_ADDR, col[15:8]);
        4'd3: s = mk(K_ADDR, row[7:0]);
        4'd4: s = mk(K_ADDR, row[15:8]);
        4'd5: s = mk(K_WDATA, 8'h00);
        4'd6: s = mk(K_CMD, 8'h10);
        4'd7: s = mk(K_WAIT, 8'h00);
        default: ;
      endcase
      OP_RPROG: case (idx)
        4'd0: s = mk(K_CMD, 8'h85);
        4'd1: s = mk(K_ADDR, col[7:0]);
        4'd2: s = mk(K_ADDR, col[15:8]);
        4'd3: s = mk(K_WDATA, 8'h00);
        4'd4: s = mk(K_CMD, 8'h10);
        4'd5: s = mk(K_WAIT, 8'h00);
        default: ;
      endcase
      OP_READ: case (idx)
        4'd0: s = mk(K_CMD, 8'h00);
        4'd1: s = mk(K_ADDR, col[7:0]);
        4'd2: s = mk(K_ADDR, col[15:8]);
        4'd3: s = mk(K_ADDR, row[7:0]);
        4'd4: s = mk(K_ADDR, row[15:8]);
        4'd5: s = mk(K_CMD, 8'h30);
        4'd6: s = mk(K_WAIT, 8'h00);
        4'd7: s = mk(K_RDATA, 8'h00);
        default: ;
      endcase
      OP_RREAD: case (idx)
        4'd0: s = mk(K_CMD, 8'h05);
        4'd1: s = mk(K_ADDR, col[7:0]);
        4'd2: s = mk(K_ADDR, col[15:8]);
        4'd3: s = mk(K_CMD, 8'hE0);
        4'd4: s = mk(K_RDATA, 8'h00);
        default: ;
      endcase
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 2,
  parameter int T_HIGH  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd,
  output logic we_n,
  output logic re_n,
  output logic sample,
  output logic cyc_done
);
  localparam int TMAX = (T_SETUP > T_LOW) ? ((T_SETUP > T_HIGH) ? T_SETUP : T_HIGH)
                                          : ((T_LOW > T_HIGH) ? T_LOW : T_HIGH);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW, P_HIGH} phase_e;
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= P_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
    end else begin
      case (ph)
        P_IDLE: if (start) begin
          ph   <= P_SETUP;
          cnt  <= CW'(T_SETUP - 1);
          rd_q <= rd;
        end
        P_SETUP: if (last) begin
          ph  <= P_LOW;
          cnt <= CW'(T_LOW - 1);
        end else cnt <= cnt - 1'b1;
        P_LOW: if (last) begin
          ph  <= P_HIGH;
          cnt <= CW'(T_HIGH - 1);
        end else cnt <= cnt - 1'b1;
        default: if (last) ph <= P_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign we_n     = !(ph == P_LOW && !rd_q);
  assign re_n     = !(ph == P_LOW && rd_q);
  assign sample   = (ph == P_LOW) && last && rd_q;
  assign cyc_done = (ph == P_HIGH) && last;

endmodule

// File: rtl/nand_seq_rbwait.sv
module nand_seq_rbwait #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb,
  output logic done,
  output logic timeout
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {W_IDLE, W_FALL, W_RISE} wst_e;
  wst_e          st;
  logic [1:0]    rb_s;
  logic [TW-1:0] tcnt;
  logic          expire, risen;

  assign risen   = (st == W_RISE) && rb_s[1];
  assign expire  = (st != W_IDLE) && (tcnt == TW'(TIMEOUT_CYC - 1));
  assign done    = risen || expire;
  assign timeout = expire && !risen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= W_IDLE;
      rb_s <= 2'b11;
      tcnt <= '0;
    end else begin
      rb_s <= {rb_s[0], rb};
      case (st)
        W_IDLE: if (start) begin
          st   <= W_FALL;
          tcnt <= '0;
        end
        W_FALL: begin
          tcnt <= tcnt + 1'b1;
          if (expire) st <= W_IDLE;
          else if (!rb_s[1]) st <= W_RISE;
        end
        default: begin
          tcnt <= tcnt + 1'b1;
          if (done) st <= W_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_host.sv
module nand_seq_host
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2112,
  parameter int LEN_W       = 12,
  parameter int T_SETUP     = 2,
  parameter int T_LOW       = 2,
  parameter int T_HIGH      = 2,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_row,
  input  logic [15:0]      req_col,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             done,
  output logic             err,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  inout  wire  [7:0]       nand_io,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  input  logic             nand_rb
);
  localparam int LOW_W = $clog2(T_LOW + 2);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_BUS, S_WAITB} st_e;

  function automatic logic [LEN_W-1:0] xfer_len(op_e op, logic [LEN_W-1:0] want);
    case (op)
      OP_STATUS:         return LEN_W'(1);
      OP_READID:         return LEN_W'(4);
      OP_RESET, OP_ERASE: return '0;
      default:           return (want > LEN_W'(PAGE_BYTES)) ? LEN_W'(PAGE_BYTES) : want;
    endcase
  endfunction

  st_e              st;
  op_e              op_q;
  logic [15:0]      row_q, col_q;
  logic [3:0]       idx;
  logic [LEN_W-1:0] rem;
  logic             cle_q, ale_q, oe_q, adv_q, done_q, err_q, rdv_q;
  logic [7:0]       dout_q, rdd_q;
  step_t            cur;

  // named internal events
  logic in_step, is_data, issue_cmd, issue_wr, issue_rd, skip_data;
  logic wait_start, finish, bus_start;
  logic sample, cyc_done, bw_done, bw_to;

  assign cur        = step_of(op_q, idx, row_q, col_q);
  assign in_step    = (st == S_STEP);
  assign is_data    = (cur.kind == K_WDATA) || (cur.kind == K_RDATA);
  assign issue_cmd  = in_step && ((cur.kind == K_CMD) || (cur.kind == K_ADDR));
  assign issue_wr   = in_step && (cur.kind == K_WDATA) && (rem != '0) && wr_valid;
  assign issue_rd   = in_step && (cur.kind == K_RDATA) && (rem != '0);
  assign skip_data  = in_step && is_data && (rem == '0);
  assign wait_start = in_step && (cur.kind == K_WAIT);
  assign finish     = in_step && (cur.kind == K_END);
  assign bus_start  = issue_cmd || issue_wr || issue_rd;

  nand_seq_strobe #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(issue_rd),
    .we_n(nand_we_n), .re_n(nand_re_n), .sample(sample), .cyc_done(cyc_done)
  );

  nand_seq_rbwait #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rbwait (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .rb(nand_rb),
    .done(bw_done), .timeout(bw_to)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_RESET; row_q <= '0; col_q <= '0;
      idx <= '0; rem <= '0; cle_q <= 1'b0; ale_q <= 1'b0; oe_q <= 1'b0;
      adv_q <= 1'b0; dout_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
      rdv_q <= 1'b0; rdd_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= sample;
      if (sample) rdd_q <= nand_io;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q  <= op_e'(req_op);
          row_q <= req_row;
          col_q <= req_col;
          rem   <= xfer_len(op_e'(req_op), req_len);
          idx   <= '0;
          st    <= S_STEP;
        end
        S_STEP: begin
          if (issue_cmd) begin
            cle_q  <= (cur.kind == K_CMD);
            ale_q  <= (cur.kind == K_ADDR);
            dout_q <= cur.val;
            oe_q   <= 1'b1;
            adv_q  <= 1'b1;
            st     <= S_BUS;
          end else if (issue_wr) begin
            dout_q <= wr_data;
            oe_q   <= 1'b1;
            adv_q  <= 1'b0;
            rem    <= rem - 1'b1;
            st     <= S_BUS;
          end else if (issue_rd) begin
            oe_q  <= 1'b0;
            adv_q <= 1'b0;
            rem   <= rem - 1'b1;
            st    <= S_BUS;
          end else if (skip_data) begin
            idx <= idx + 1'b1;
          end else if (wait_start) begin
            st <= S_WAITB;
          end else if (finish) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_BUS: if (cyc_done) begin
          cle_q <= 1'b0;
          ale_q <= 1'b0;
          oe_q  <= 1'b0;
          if (adv_q) idx <= idx + 1'b1;
          st <= S_STEP;
        end
        default: if (bw_done) begin
          if (bw_to) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_STEP;
          end
        end
      endcase
    end
  end

  assign nand_io   = oe_q ? dout_q : 8'hzz;
  assign nand_cle  = cle_q;
  assign nand_ale  = ale_q;
  assign nand_ce_n = (st == S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign wr_ready  = in_step && (cur.kind == K_WDATA) && (rem != '0);
  assign done      = done_q;
  assign err       = err_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;

  // strobe-low run length, for the width property
  logic [LOW_W-1:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_cnt <= '0;
    else if (!nand_we_n || !nand_re_n) lo_cnt <= lo_cnt + 1'b1;
    else lo_cnt <= '0;
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n && !oe_q && !nand_cle && !nand_ale));
  // R2
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable({nand_cle, nand_ale, dout_q}));
  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R6
  host_off_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !oe_q);
  // R7
  quiet_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITB) |-> (nand_we_n && nand_re_n));
  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R9
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= LEN_W'(PAGE_BYTES));
  // R10
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n && nand_re_n) |-> (lo_cnt == LOW_W'(T_LOW)));

endmodule

// File: tb/nand_seq_host_bench.sv
`timescale 1ns/1ps
module nand_seq_host_bench;
  localparam int TS = 2, TL = 3, TH = 1, TO = 300, PAGE = 2112;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, wr_valid = 1'b1;
  logic [2:0] req_op = '0;
  logic [15:0] req_row = '0, req_col = '0;
  logic [11:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic nand_rb = 1'b1;
  wire [7:0] nand_io;
  wire req_ready, done, err, wr_ready, rd_valid;
  wire [7:0] rd_data;
  wire nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n;

  always #4 clk = ~clk;

  nand_seq_host #(.PAGE_BYTES(PAGE), .LEN_W(12), .T_SETUP(TS), .T_LOW(TL),
                  .T_HIGH(TH), .TIMEOUT_CYC(TO)) u_nand_seq_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .req_ready(req_ready), .done(done), .err(err),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .nand_io(nand_io),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb(nand_rb));

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(int n);  return 8'((n * 13) ^ 8'h5A); endfunction
  function automatic logic [7:0] rpat(int a);  return 8'((a * 7) ^ (a >> 8) ^ 8'h3C); endfunction

  // ---------------- flash model ----------------
  int log_k [2200];
  logic [7:0] log_b [2200];
  int nlog = 0, naddr = 0, rptr = 0, idc = 0, conf_ev = 0;
  logic [7:0] maddr [4];
  logic [7:0] last_cmd = 8'hFF, mdl_q = 8'h00;
  bit stuck = 0;
  wire mdl_oe = !nand_ce_n && !nand_re_n;
  assign nand_io = mdl_oe ? mdl_q : 8'hzz;

  always @(posedge nand_we_n) if (!nand_ce_n) begin
    if (nlog < 2200) begin
      log_k[nlog] = nand_cle ? 0 : (nand_ale ? 1 : 2);
      log_b[nlog] = nand_io;
    end
    nlog++;
    if (nand_cle) begin
      last_cmd = nand_io;
      naddr = 0;
      case (nand_io)
        8'h10, 8'hD0, 8'hFF: if (!stuck) conf_ev++;
        8'h30: begin rptr = {maddr[1], maddr[0]}; if (!stuck) conf_ev++; end
        8'hE0: rptr = {maddr[1], maddr[0]};
        8'h90: idc = 0;
        default: ;
      endcase
    end else if (nand_ale) begin
      if (naddr < 4) maddr[naddr] = nand_io;
      naddr++;
    end
  end

  always @(negedge nand_re_n) if (!nand_ce_n) begin
    case (last_cmd)
      8'h70: mdl_q = 8'hE0;
      8'h90: begin
        case (idc) 0: mdl_q = 8'hEC; 1: mdl_q = 8'hF1; 2: mdl_q = 8'h00; default: mdl_q = 8'h15; endcase
        idc++;
      end
      default: begin mdl_q = rpat(rptr); rptr++; end
    endcase
  end

  // ---------------- negedge monitor / write source ----------------
  int seen_ev = 0, bz = 0, rb_lows = 0, busy_strobe = 0, run = 0, wbad = 0, nstrobes = 0;
  int cont = 0, wr_n = 0, nrd = 0;
  bit wr_pend = 0, got_done = 0, got_err = 0;
  logic [7:0] rd_log [2200];

  always @(negedge clk) begin
    if (conf_ev != seen_ev) begin seen_ev = conf_ev; bz = 25; end
    else if (bz > 0) bz--;
    nand_rb = !(bz > 0 && bz <= 20);
    if (!nand_rb) rb_lows++;
    if (!nand_rb && (!nand_we_n || !nand_re_n)) busy_strobe++;
    if (!nand_we_n || !nand_re_n) run++;
    else if (run > 0) begin
      if (run != TL) wbad++;
      nstrobes++;
      run = 0;
    end
    if (!nand_re_n && nand_io !== mdl_q) cont++;
    if (wr_pend) wr_n++;
    wr_pend = wr_ready && wr_valid;
    wr_data = wpat(wr_n);
    if (rd_valid) begin
      if (nrd < 2200) rd_log[nrd] = rd_data;
      nrd++;
    end
    if (done) begin got_done = 1; got_err = err; end
  end

  // ---------------- expected sequences ----------------
  int ek [2200];
  logic [7:0] eb [2200];
  int ne = 0;
  function automatic void push(int k, logic [7:0] b);
    ek[ne] = k; eb[ne] = b; ne++;
  endfunction

  task automatic run_op(input int op, input logic [15:0] row, input logic [15:0] col,
                        input int len, input bit exp_err);
    int n, wb, nexp_rd, lim;
    n  = (len > PAGE) ? PAGE : len;
    wb = wr_n;
    ne = 0;
    case (op)
      0: push(0, 8'hFF);
      1: push(0, 8'h70);
      2: begin push(0, 8'h90); push(1, 8'h00); end
      3: begin push(0, 8'h60); push(1, row[7:0]); push(1, row[15:8]); push(0, 8'hD0); end
      4: begin
        push(0, 8'h80); push(1, col[7:0]); push(1, col[15:8]); push(1, row[7:0]); push(1, row[15:8]);
        for (int i = 0; i < n; i++) push(2, wpat(wb + i));
        push(0, 8'h10);
      end
      5: begin
        push(0, 8'h85); push(1, col[7:0]); push(1, col[15:8]);
        for (int i = 0; i < n; i++) push(2, wpat(wb + i));
        push(0, 8'h10);
      end
      6: begin
        push(0, 8'h00); push(1, col[7:0]); push(1, col[15:8]); push(1, row[7:0]); push(1, row[15:8]);
        push(0, 8'h30);
      end
      default: begin push(0, 8'h05); push(1, col[7:0]); push(1, col[15:8]); push(0, 8'hE0); end
    endcase
    nlog = 0; nrd = 0; rb_lows = 0; got_done = 0; got_err = 0;
    @(negedge clk);
    req_op = 3'(op); req_row = row; req_col = col; req_len = 12'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lim = 0;
    while (!got_done && lim < 40000) begin @(negedge clk); lim++; end
    chk(got_done == 1, "R4 done seen", got_done, 1);
    chk(got_err == exp_err, "R8 err flag", got_err, exp_err);
    if (exp_err) return;
    chk(nlog == ne, "R4 bus cycle count", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++)
      chk(log_k[i] == ek[i] && log_b[i] == eb[i],
          (ek[i] == 2) ? "R5 write data byte" : ((ek[i] == 1) ? "R3 address byte" : "R2 command byte"),
          {log_k[i], log_b[i]}, {ek[i], eb[i]});
    if (op == 4 || op == 5) chk(wr_n - wb == n, "R9 bytes written", wr_n - wb, n);
    case (op)
      1: nexp_rd = 1;
      2: nexp_rd = 4;
      6, 7: nexp_rd = n;
      default: nexp_rd = 0;
    endcase
    chk(nrd == nexp_rd, "R9 bytes read", nrd, nexp_rd);
    for (int i = 0; i < nexp_rd && i < nrd; i++) begin
      logic [7:0] e;
      if (op == 1) e = 8'hE0;
      else if (op == 2) e = (i == 0) ? 8'hEC : (i == 1) ? 8'hF1 : (i == 2) ? 8'h00 : 8'h15;
      else e = rpat(int'(col) + i);
      chk(rd_log[i] == e, "R6 read byte", rd_log[i], e);
    end
    if (op == 0 || op == 3 || op == 4 || op == 5 || op == 6)
      chk(rb_lows >= 20, "R7 busy wait observed", rb_lows, 20);
    else
      chk(rb_lows == 0, "R11 no busy wait", rb_lows, 0);
    chk(req_ready == 1, "R1 idle after op", req_ready, 1);
  endtask

  localparam int NV = 9;
  localparam logic [46:0] VEC [NV] = '{
    {3'd0, 16'h0000, 16'h0000, 12'd0},
    {3'd1, 16'h0000, 16'h0000, 12'd0},
    {3'd2, 16'h0000, 16'h0000, 12'd0},
    {3'd3, 16'h1234, 16'h0000, 12'd0},
    {3'd4, 16'h0102, 16'h0010, 12'd5},
    {3'd5, 16'h0000, 16'h0835, 12'd3},
    {3'd6, 16'h0102, 16'h0004, 12'd6},
    {3'd7, 16'h0000, 16'h0200, 12'd4},
    {3'd4, 16'h0007, 16'h0000, 12'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n == 1 && nand_we_n == 1 && nand_re_n == 1, "R1 strobes/ce in reset",
        {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(nand_cle == 0 && nand_ale == 0 && nand_io === 8'hzz, "R1 latches/io in reset",
        {nand_cle, nand_ale}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && nand_ce_n == 1 && nand_io === 8'hzz, "R1 idle after reset",
        {req_ready, nand_ce_n}, 2'b11);

    for (int v = 0; v < NV; v++)
      run_op(int'(VEC[v][46:44]), VEC[v][43:28], VEC[v][27:12], int'(VEC[v][11:0]), 1'b0);

    // R9 clamp on program and read
    run_op(4, 16'h0033, 16'h0000, 3000, 1'b0);
    run_op(6, 16'h0033, 16'h0000, 4000, 1'b0);

    // R8 timeout: ready/busy never moves
    stuck = 1;
    run_op(3, 16'h0055, 16'h0000, 0, 1'b1);
    // R11 random read, status and ID need no busy wait
    run_op(7, 16'h0000, 16'h0010, 2, 1'b0);
    run_op(1, 16'h0000, 16'h0000, 0, 1'b0);
    run_op(2, 16'h0000, 16'h0000, 0, 1'b0);
    stuck = 0;
    run_op(0, 16'h0000, 16'h0000, 0, 1'b0);

    // R10 strobe widths, R7 no strobe while busy, R6 no contention
    chk(wbad == 0 && nstrobes > 0, "R10 strobe low width", wbad, 0);
    chk(busy_strobe == 0, "R7 strobe during busy", busy_strobe, 0);
    chk(cont == 0, "R6 data lines released during read", cont, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule